// File: doc/BRIEF.md
# I2C Slave Address Match and Acknowledge Decision

This block decides how the device answers the acknowledge slot of an I2C byte. It handles the first byte after a START while the device is a slave. The upper seven bits of that byte are compared with a programmable own address. The all-zero general-call address can also be recognised when it is enabled. The block then chooses whether to pull SDA low (ACK) or leave it high (NACK) during the ninth clock. The same decision applies to data bytes received as a master receiver and as an addressed slave receiver.

A software-owned acknowledge-enable flag lets the device step off the bus without losing track of it. While the flag is clear, the device is never addressed and never interrupts. START and STOP tracking still runs, and so does the decision for each byte. The flag is read only when a byte completes. Setting it part-way through an address byte therefore still lets that byte be recognised.

A shifter elsewhere supplies the received byte and a one-cycle byte-complete strobe. Bus-condition detectors supply one-cycle START and STOP pulses. The block returns the SDA level for the acknowledge slot and a one-cycle interrupt request.

Top module: `i2c_addr_ack`

## Requirements
- R1: After reset, `ack_sda` is 1 (released), and `irq`, `addr_match`, `gc_hit` and `rd_dir` are all 0.
- R2: In slave mode (`mode`=2'b00), the first byte-complete strobe after a START matches when `rx_byte[7:1]` equals `own_addr[6:0]`, so `rx_byte[7]` is compared with `own_addr[6]`. `rx_byte[0]` takes no part in the comparison. With `ack_en`=1, a match sets `addr_match`, drives `ack_sda`=0 and pulses `irq`, all in the cycle after the strobe.
- R3: When an own-address match is accepted, `rd_dir` takes the value of `rx_byte[0]`, where 1 means the master reads. After a general-call match, `rd_dir` is 0.
- R4: An address byte of 8'h00 with `gc_en`=1 and `ack_en`=1 sets `gc_hit`, drives `ack_sda`=0 and pulses `irq`. With `gc_en`=0 that byte is ignored. If it also matches the own address, `addr_match` is set instead of `gc_hit`.
- R5: If `ack_en`=0 at the strobe of an address byte, neither the own address nor the general call is recognised. In that case `ack_sda` stays 1 and `irq` stays 0.
- R6: For a data byte received as an addressed slave receiver (`rd_dir`=0), `ack_sda` becomes the inverse of `ack_en` and `irq` pulses.
- R7: In master receiver mode (`mode`=2'b10), each byte-complete strobe gives `ack_sda` equal to the inverse of `ack_en` and pulses `irq`. In master modes (2'b01 or 2'b10), `addr_match` and `gc_hit` stay 0 whatever the address byte is.
- R8: For bytes received in slave mode while not addressed, `ack_sda` is 1 and `irq` stays 0.
- R9: `ack_en` is sampled only on the cycle of the byte-complete strobe. A value it had earlier in the byte has no effect.
- R10: A STOP or a new START clears `addr_match`, `gc_hit` and `rd_dir` in the next cycle.
- R11: `irq` is high for exactly one cycle per accepted strobe.
- R12: For a byte-complete strobe as an addressed slave transmitter (`rd_dir`=1) or as a master transmitter (`mode`=2'b01), `ack_sda` is 1 and `irq` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_seen | input | 1 | One-cycle pulse on a START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on a STOP |
| byte_done | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte, first bus bit in bit 7 |
| own_addr | input | 7 | Own slave address |
| gc_en | input | 1 | Enables recognition of general call 8'h00 |
| ack_en | input | 1 | Software acknowledge-enable flag |
| mode | input | 2 | 00 slave, 01 master transmitter, 10 master receiver |
| addr_match | output | 1 | Addressed through the own address |
| gc_hit | output | 1 | Addressed through the general call |
| rd_dir | output | 1 | Direction bit of the accepted address byte |
| ack_sda | output | 1 | SDA level for the acknowledge slot (0 = ACK) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The main function is swept over every one of the 256 address bytes. Each sweep is repeated for four own addresses, including all-zeros and all-ones, and for all four settings of `gc_en` and `ack_en`. Together these runs separate four things: the address comparison, the priority of the own address over the general call, the R/W bit being left out of the comparison, and the gating by `ack_en`. Directed sequences then cover the rest: data bytes in each receiver and transmitter role, bytes while not addressed, `ack_en` changing inside a byte, and START or STOP clearing the addressed state.

// File: rtl/i2c_ack_pkg.sv
// Shared types for the address-match and acknowledge block.
package i2c_ack_pkg;
    typedef enum logic [1:0] {
        MODE_SLAVE = 2'b00,
        MODE_MTX   = 2'b01,
        MODE_MRX   = 2'b10,
        MODE_RSVD  = 2'b11
    } bus_mode_e;
endpackage

// File: rtl/i2c_addr_cmp.sv
// Address comparator: compares a received byte against the own address
// and against the general-call code. Purely combinational; assumes the
// direction bit sits in bit 0 of the byte.
module i2c_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    output logic              own_hit,
    output logic              gc_code
);
    // Compare the address field and detect an enabled general call.
    always_comb begin
        own_hit = (rx_byte[ADDR_W:1] == own_addr);
        gc_code = gc_en && (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_ack_decide.sv
// Acknowledge decision: given the role and addressing state at the end
// of a byte, picks the SDA level for the ninth clock, whether to request
// an interrupt and whether the byte addresses this device. Combinational.
module i2c_ack_decide
    import i2c_ack_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       first_byte,
    input  logic       addressed,
    input  logic       dir_rd,
    input  logic       ack_en,
    input  logic       own_hit,
    input  logic       gc_code,
    output logic       take_own,
    output logic       take_gc,
    output logic       ack_lvl,
    output logic       irq_req
);
    // Select the acknowledge level and interrupt for the finished byte.
    always_comb begin
        take_own = 1'b0;
        take_gc  = 1'b0;
        ack_lvl  = 1'b1;
        irq_req  = 1'b0;
        unique case (bus_mode_e'(mode))
            MODE_MRX: begin
                ack_lvl = ~ack_en;
                irq_req = 1'b1;
            end
            MODE_MTX: begin
                irq_req = 1'b1;
            end
            MODE_SLAVE: begin
                if (first_byte) begin
                    if (ack_en && own_hit) begin
                        take_own = 1'b1;
                        ack_lvl  = 1'b0;
                        irq_req  = 1'b1;
                    end else if (ack_en && gc_code) begin
                        take_gc  = 1'b1;
                        ack_lvl  = 1'b0;
                        irq_req  = 1'b1;
                    end
                end else if (addressed) begin
                    ack_lvl = dir_rd ? 1'b1 : ~ack_en;
                    irq_req = 1'b1;
                end
            end
            default: begin
                ack_lvl = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/i2c_addr_ack.sv
// Top: tracks the first byte after START and the addressed state, and
// registers the acknowledge level and interrupt pulse one cycle after
// each byte-complete strobe. Assumes START/STOP/byte strobes are single
// cycle pulses from an external detector and shifter.
module i2c_addr_ack
    import i2c_ack_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic [1:0]        mode,
    output logic              addr_match,
    output logic              gc_hit,
    output logic              rd_dir,
    output logic              ack_sda,
    output logic              irq
);
    logic first_q, own_q, gc_q, dir_q, ack_q, irq_q;
    logic own_hit, gc_code, take_own, take_gc, ack_lvl, irq_req;

    i2c_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .rx_byte (rx_byte),
        .own_addr(own_addr),
        .gc_en   (gc_en),
        .own_hit (own_hit),
        .gc_code (gc_code)
    );

    i2c_ack_decide u_dec (
        .mode      (mode),
        .first_byte(first_q),
        .addressed (own_q | gc_q),
        .dir_rd    (dir_q),
        .ack_en    (ack_en),
        .own_hit   (own_hit),
        .gc_code   (gc_code),
        .take_own  (take_own),
        .take_gc   (take_gc),
        .ack_lvl   (ack_lvl),
        .irq_req   (irq_req)
    );

    // Track bus framing, addressed state and the acknowledge outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            own_q   <= 1'b0;
            gc_q    <= 1'b0;
            dir_q   <= 1'b0;
            ack_q   <= 1'b1;
            irq_q   <= 1'b0;
        end else if (start_seen || stop_seen) begin
            first_q <= start_seen;
            own_q   <= 1'b0;
            gc_q    <= 1'b0;
            dir_q   <= 1'b0;
            ack_q   <= 1'b1;
            irq_q   <= 1'b0;
        end else if (byte_done) begin
            first_q <= 1'b0;
            ack_q   <= ack_lvl;
            irq_q   <= irq_req;
            if (bus_mode_e'(mode) != MODE_SLAVE) begin
                own_q <= 1'b0;
                gc_q  <= 1'b0;
            end else if (take_own) begin
                own_q <= 1'b1;
                dir_q <= rx_byte[0];
            end else if (take_gc) begin
                gc_q  <= 1'b1;
                dir_q <= 1'b0;
            end
        end else begin
            irq_q <= 1'b0;
            if (bus_mode_e'(mode) != MODE_SLAVE) begin
                own_q <= 1'b0;
                gc_q  <= 1'b0;
            end
        end
    end

    assign addr_match = own_q;
    assign gc_hit     = gc_q;
    assign rd_dir     = dir_q;
    assign ack_sda    = ack_q;
    assign irq        = irq_q;
endmodule

// File: rtl/i2c_addr_ack_chk.sv
// Checker for i2c_addr_ack: temporal properties on ports plus the
// first-byte flag, attached by bind below.
module i2c_addr_ack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       byte_done,
    input logic       ack_en,
    input logic [1:0] mode,
    input logic       first_q,
    input logic       addr_match,
    input logic       gc_hit,
    input logic       ack_sda,
    input logic       irq
);
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_match && gc_hit)); // R4
    AST_CLEAR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen || stop_seen) |=> (!addr_match && !gc_hit)); // R10
    AST_MRX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && mode == 2'b10 && !start_seen && !stop_seen)
        |=> (irq && ack_sda == !$past(ack_en))); // R7
    AST_MASTER_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |=> (!addr_match && !gc_hit)); // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && mode == 2'b00 && !first_q && !addr_match && !gc_hit
         && !start_seen && !stop_seen) |=> (ack_sda && !irq)); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq || $past(byte_done)); // R11
endmodule

bind i2c_addr_ack i2c_addr_ack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .byte_done (byte_done),
    .ack_en    (ack_en),
    .mode      (mode),
    .first_q   (first_q),
    .addr_match(addr_match),
    .gc_hit    (gc_hit),
    .ack_sda   (ack_sda),
    .irq       (irq)
);

// File: tb/i2c_addr_ack_bench.sv
module i2c_addr_ack_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_seen = 1'b0, stop_seen = 1'b0, byte_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [6:0] own_addr = '0;
    logic       gc_en = 1'b0, ack_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       addr_match, gc_hit, rd_dir, ack_sda, irq;
    int         errors = 0;
    int         checks = 0;

    always #5 clk = ~clk;

    i2c_addr_ack u_i2c_addr_ack (
        .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
        .byte_done(byte_done), .rx_byte(rx_byte), .own_addr(own_addr),
        .gc_en(gc_en), .ack_en(ack_en), .mode(mode), .addr_match(addr_match),
        .gc_hit(gc_hit), .rd_dir(rd_dir), .ack_sda(ack_sda), .irq(irq)
    );

    // Packed observation: {addr_match, gc_hit, rd_dir, ack_sda, irq}
    function automatic logic [4:0] obs();
        return {addr_match, gc_hit, rd_dir, ack_sda, irq};
    endfunction

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_seen = 1'b1;
        @(negedge clk) start_seen = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_seen = 1'b1;
        @(negedge clk) stop_seen = 1'b0;
    endtask

    // Present a byte; returns at the negedge after the registering edge.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) begin rx_byte = b; byte_done = 1'b1; end
        @(negedge clk) byte_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0] owns [4] = '{7'h00, 7'h2A, 7'h55, 7'h7F};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(obs(), 5'b00010, "R1 reset");

        // Exhaustive address sweep (R2, R3, R4, R5)
        foreach (owns[k]) begin
            for (int g = 0; g < 2; g++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        logic oh, gh, tk, tg;
                        logic [4:0] e;
                        own_addr = owns[k];
                        gc_en    = g[0];
                        ack_en   = a[0];
                        pulse_start();
                        send_byte(b[7:0]);
                        oh = (b[7:1] == owns[k]);
                        gh = g[0] && (b == 0);
                        tk = a[0] && oh;
                        tg = a[0] && !oh && gh;
                        e  = {tk, tg, tk & b[0], !(tk | tg), tk | tg};
                        check(obs(), e, !a[0] ? "R5 ack_en low" :
                              (gh ? "R4 general call" : "R2/R3 own address"));
                    end
                end
            end
        end

        // Addressed slave receiver data (R6, R11)
        own_addr = 7'h2A; gc_en = 1'b0; ack_en = 1'b1;
        pulse_start(); send_byte(8'h54);
        send_byte(8'hA5);
        check(obs(), 5'b10001, "R6 data ack");
        @(negedge clk);
        check(obs(), 5'b10000, "R11 irq single pulse");
        ack_en = 1'b0;
        send_byte(8'h3C);
        check(obs(), 5'b10011, "R6 data nack");

        // ack_en changes inside a byte (R9)
        pulse_start();
        @(negedge clk) ack_en = 1'b0;
        @(negedge clk) ack_en = 1'b1;
        send_byte(8'h54);
        check(obs(), 5'b10001, "R9 late ack_en accepted");
        ack_en = 1'b1;
        @(negedge clk) ack_en = 1'b0;
        send_byte(8'h11);
        check(obs(), 5'b10011, "R9 late clear gives nack");

        // STOP and START clear (R10)
        ack_en = 1'b1;
        pulse_stop();
        check(obs(), 5'b00010, "R10 stop clears");
        pulse_start(); send_byte(8'h55);
        check(obs(), 5'b10101, "R3 read direction");
        pulse_start();
        check(obs(), 5'b00010, "R10 start clears");

        // Not-addressed data bytes (R8)
        send_byte(8'h22);
        send_byte(8'h54);
        check(obs(), 5'b00010, "R8 unaddressed data");

        // Addressed slave transmitter (R12)
        pulse_start(); send_byte(8'h55);
        send_byte(8'h99);
        check(obs(), 5'b10111, "R12 slave transmitter");

        // Master modes (R7, R12)
        pulse_stop();
        mode = 2'b10;
        pulse_start(); send_byte(8'h54);
        check(obs(), 5'b00001, "R7 address ignored in master rx");
        ack_en = 1'b1; send_byte(8'h12);
        check(obs(), 5'b00001, "R7 master rx ack");
        ack_en = 1'b0; send_byte(8'h34);
        check(obs(), 5'b00011, "R7 master rx nack");
        mode = 2'b01;
        send_byte(8'h56);
        check(obs(), 5'b00011, "R12 master transmitter");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule